// File: doc/BRIEF.md
# DMA Interrupt Coalescing Unit

This block moderates completion interrupts for one DMA channel. It holds a countdown of completion events. When the countdown runs out, it raises an on-complete set pulse and restarts from a programmable threshold. It also runs an inactivity timer, which each completion reloads. If no further completion arrives before the timer runs out, the block raises a delay set pulse, and that expiry also restarts the completion countdown.

The threshold and delay values arrive as plain fields from the channel's control register. The block sees a strobe each time that register is written, a pulse per finished transfer, and a free-running tick enable that a parameterised prescaler divides down. The flag registers, their clearing and the register bus sit outside. The live countdown and timer values leave the block for status readback.

Top module: `irq_coalescer`

## Requirements
- R1: After reset the countdown holds INIT_COUNT (default 1), the timer holds 0, and both set pulses are low.
- R2: A cycle with `ctrl_wr` high loads the countdown from `cfg_threshold` on the next edge. In that cycle a completion cannot produce `ioc_set`, and the countdown does not decrement.
- R3: Each `done_pulse` without `ctrl_wr` lowers the countdown by one. The new value shows on `remaining_cnt` after the clock edge.
- R4: A completion that finds the countdown at 1 gives a one-cycle `ioc_set` one cycle later, and the countdown reloads from `cfg_threshold`.
- R5: A threshold of 0 wraps the countdown, so 256 completions (with the default 8-bit width) are needed for one `ioc_set`.
- R6: A completion with a nonzero `cfg_delay` loads the timer with `cfg_delay` and clears the prescaler phase.
- R7: While the timer is nonzero it decrements once per PRESCALE `tick_en` pulses (default 4). Ticks while the timer is 0 change nothing.
- R8: When the timer steps from 1 to 0 the block gives a one-cycle `dly_set`, and the countdown reloads from `cfg_threshold`.
- R9: A completion with `cfg_delay` equal to 0 leaves the timer and prescaler running as they were.
- R10: If a completion with nonzero `cfg_delay` falls in the cycle in which the timer would expire, the timer reloads and no `dly_set` is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_threshold | input | CNT_W | Completion count that triggers on-complete |
| cfg_delay | input | DLY_W | Inactivity timer load value, 0 disables restart |
| ctrl_wr | input | 1 | Control register written this cycle |
| done_pulse | input | 1 | One transfer completed this cycle |
| tick_en | input | 1 | Timer base tick before prescaling |
| ioc_set | output | 1 | Set pulse for the on-complete flag |
| dly_set | output | 1 | Set pulse for the delay flag |
| remaining_cnt | output | CNT_W | Live completion countdown |
| delay_cnt | output | DLY_W | Live inactivity timer value |

## Verification
The hardest case to reach is a completion arriving in exactly the cycle in which the timer would expire. To get there, the timer must be at 1 and the prescaler at its last phase, with a tick present. The stimulus loads a small delay and then feeds a counted run of ticks until the prescaler phase and timer value are both known. It then applies the completion together with the final tick. A second run does the same with a zero delay, so that expiry and completion act together. A reference model in the bench follows every cycle, so each of these alignments is compared on all outputs.

// File: rtl/irq_coalescer.sv
module irq_coalescer #(
  parameter int CNT_W      = 8,
  parameter int DLY_W      = 8,
  parameter int PRESCALE   = 4,
  parameter int INIT_COUNT = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] cfg_threshold,
  input  logic [DLY_W-1:0] cfg_delay,
  input  logic             ctrl_wr,
  input  logic             done_pulse,
  input  logic             tick_en,
  output logic             ioc_set,
  output logic             dly_set,
  output logic [CNT_W-1:0] remaining_cnt,
  output logic [DLY_W-1:0] delay_cnt
);

  localparam int PW = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
  localparam logic [PW-1:0] PLAST = PW'(PRESCALE - 1);

  logic [CNT_W-1:0] cnt_q;
  logic [DLY_W-1:0] tmr_q;
  logic [PW-1:0]    pre_q;
  logic             ioc_q, dly_q;

  wire running   = (tmr_q != '0);
  wire step      = tick_en && running && (pre_q == PLAST);
  wire expire    = step && (tmr_q == DLY_W'(1));
  wire restart   = done_pulse && (cfg_delay != '0);
  wire dly_fire  = expire && !restart;
  wire cnt_last  = (cnt_q == CNT_W'(1));
  wire ioc_fire  = done_pulse && !ctrl_wr && cnt_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= CNT_W'(INIT_COUNT);
    end else if (ctrl_wr || dly_fire) begin
      cnt_q <= cfg_threshold;
    end else if (done_pulse) begin
      cnt_q <= cnt_last ? cfg_threshold : cnt_q - CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tmr_q <= '0;
      pre_q <= '0;
    end else if (restart) begin
      tmr_q <= cfg_delay;
      pre_q <= '0;
    end else if (tick_en && running) begin
      pre_q <= step ? '0 : pre_q + PW'(1);
      if (step) tmr_q <= tmr_q - DLY_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ioc_q <= 1'b0;
      dly_q <= 1'b0;
    end else begin
      ioc_q <= ioc_fire;
      dly_q <= dly_fire;
    end
  end

  assign ioc_set       = ioc_q;
  assign dly_set       = dly_q;
  assign remaining_cnt = cnt_q;
  assign delay_cnt     = tmr_q;

  AST_CTRL_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wr |=> (remaining_cnt == $past(cfg_threshold)) && !ioc_set); // R2
  AST_IOC_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    ioc_set |-> remaining_cnt == $past(cfg_threshold)); // R4
  AST_IOC_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    ioc_set |=> !ioc_set || $past(done_pulse)); // R4
  AST_RESTART_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (done_pulse && cfg_delay != '0) |=> (delay_cnt == $past(cfg_delay)) && !dly_set); // R6
  AST_TIMER_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !(done_pulse && cfg_delay != '0) |=> (delay_cnt == $past(delay_cnt)) || (delay_cnt == $past(delay_cnt) - DLY_W'(1))); // R7
  AST_DLY_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    dly_set |-> (delay_cnt == '0) && (remaining_cnt == $past(cfg_threshold))); // R8
  AST_IDLE_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (delay_cnt == '0 && !done_pulse) |=> delay_cnt == '0 && !dly_set); // R7

endmodule

// File: tb/tb_irq_coalescer.sv
module tb_irq_coalescer;
  localparam int P = 4;

  logic clk = 0, rst_n = 0;
  logic [7:0] cfg_threshold = 0, cfg_delay = 0;
  logic ctrl_wr = 0, done_pulse = 0, tick_en = 0;
  logic ioc_set, dly_set;
  logic [7:0] remaining_cnt, delay_cnt;

  irq_coalescer #(.CNT_W(8), .DLY_W(8), .PRESCALE(P), .INIT_COUNT(1)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_threshold(cfg_threshold), .cfg_delay(cfg_delay),
    .ctrl_wr(ctrl_wr), .done_pulse(done_pulse), .tick_en(tick_en),
    .ioc_set(ioc_set), .dly_set(dly_set), .remaining_cnt(remaining_cnt), .delay_cnt(delay_cnt));

  always #2 clk = ~clk;

  typedef struct { logic ioc; logic dly; logic [7:0] cnt; logic [7:0] tmr; string tag; } exp_t;
  exp_t q[$];
  int checks = 0, errors = 0;
  int ioc_seen = 0, dly_seen = 0;
  logic [7:0] m_cnt, m_tmr;
  int m_pre;
  bit started = 0, finished = 0;

  task automatic check(input bit ok, input string tag, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic cyc(input bit d, input bit w, input bit t, input string tag);
    exp_t e;
    bit step, expire, restart, dfire;
    @(negedge clk);
    done_pulse = d; ctrl_wr = w; tick_en = t;
    step    = t && m_tmr != 0 && m_pre == P-1;
    expire  = step && m_tmr == 1;
    restart = d && cfg_delay != 0;
    dfire   = expire && !restart;
    e.ioc = d && !w && m_cnt == 1;
    e.dly = dfire;
    if (w || dfire) m_cnt = cfg_threshold;
    else if (d) m_cnt = (m_cnt == 1) ? cfg_threshold : m_cnt - 8'd1;
    if (restart) begin m_tmr = cfg_delay; m_pre = 0; end
    else if (t && m_tmr != 0) begin
      if (step) begin m_tmr = m_tmr - 8'd1; m_pre = 0; end
      else m_pre = m_pre + 1;
    end
    e.cnt = m_cnt; e.tmr = m_tmr; e.tag = tag;
    q.push_back(e);
  endtask

  initial begin : monitor
    exp_t e;
    forever begin
      @(posedge clk); #1;
      if (started && q.size() > 0) begin
        e = q.pop_front();
        if (ioc_set) ioc_seen++;
        if (dly_set) dly_seen++;
        check(ioc_set === e.ioc, e.tag, "ioc_set", int'(ioc_set), int'(e.ioc));
        check(dly_set === e.dly, e.tag, "dly_set", int'(dly_set), int'(e.dly));
        check(remaining_cnt === e.cnt, e.tag, "remaining_cnt", int'(remaining_cnt), int'(e.cnt));
        check(delay_cnt === e.tmr, e.tag, "delay_cnt", int'(delay_cnt), int'(e.tmr));
      end
    end
  end

  initial begin : watchdog
    #(4 * 20000);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : driver
    int base;
    repeat (3) @(negedge clk);
    // R1: reset state
    check(remaining_cnt === 8'd1, "R1", "remaining_cnt", int'(remaining_cnt), 1);
    check(delay_cnt === 8'd0, "R1", "delay_cnt", int'(delay_cnt), 0);
    check(!ioc_set && !dly_set, "R1", "pulses", int'({ioc_set, dly_set}), 0);
    rst_n = 1;
    m_cnt = 8'd1; m_tmr = 8'd0; m_pre = 0;
    started = 1;
    cyc(0, 0, 1, "R1_idle_tick");

    cfg_threshold = 8'd3; cfg_delay = 8'd0;
    cyc(0, 1, 0, "R2");
    for (int i = 0; i < 6; i++) cyc(1, 0, 0, "R3_R4");
    cyc(0, 0, 0, "R4");
    base = ioc_seen;
    cyc(1, 0, 0, "R3");
    cyc(1, 1, 0, "R2_same_cycle");
    cyc(1, 0, 0, "R3");
    cyc(1, 0, 1, "R7_idle_tick");

    cfg_threshold = 8'd0;
    cyc(0, 1, 0, "R2");
    for (int i = 0; i < 256; i++) cyc(1, 0, 0, "R5");
    cyc(0, 0, 0, "R5");
    cyc(0, 0, 0, "R5");

    cfg_threshold = 8'd10; cfg_delay = 8'd5;
    cyc(0, 1, 0, "R2");
    cyc(0, 0, 1, "R7_tick");
    cyc(1, 0, 0, "R6");
    for (int i = 0; i < 24; i++) cyc(0, 0, (i % 3) != 2, "R7_R8");
    for (int i = 0; i < 8; i++) cyc(0, 0, 1, "R8");

    cfg_delay = 8'd3;
    cyc(1, 0, 0, "R6");
    cyc(0, 0, 1, "R7");
    cyc(0, 0, 1, "R7");
    cfg_delay = 8'd0;
    cyc(1, 0, 1, "R9");
    for (int i = 0; i < 12; i++) cyc(0, 0, 1, "R9_R8");

    cfg_delay = 8'd1;
    cyc(1, 0, 0, "R6");
    cyc(0, 0, 1, "R10");
    cyc(0, 0, 1, "R10");
    cyc(0, 0, 1, "R10");
    cyc(1, 0, 1, "R10_collide");
    cyc(0, 0, 0, "R10");
    for (int i = 0; i < 6; i++) cyc(0, 0, 1, "R10_R8");

    cfg_delay = 8'd1;
    cyc(1, 0, 0, "R6");
    cyc(0, 0, 1, "R9"); cyc(0, 0, 1, "R9"); cyc(0, 0, 1, "R9");
    cfg_delay = 8'd0;
    cyc(1, 0, 1, "R9_collide");
    cyc(0, 0, 0, "R9");

    @(negedge clk); done_pulse = 0; ctrl_wr = 0; tick_en = 0;
    while (q.size() > 0) @(negedge clk);
    check(ioc_seen > base, "R4", "ioc pulses seen", ioc_seen, base + 1);
    check(dly_seen >= 3, "R8", "dly pulses seen", dly_seen, 3);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule